// File: doc/BRIEF.md
# Programmable Periodic-Rate and Square-Wave Generator

This block turns a 32768 Hz reference into a selectable square wave and a periodic event. The reference arrives as a level signal, is brought into the system clock domain, and advances a free-running binary divider on each of its rising edges. A 4-bit rate code picks one divider tap. Codes 3 to 15 give 8192 Hz down to 2 Hz, halving with each step. Codes 1 and 2 are aliases of 8 and 9. Code 0 turns the rate off.

The selected tap drives the wave pin when the wave enable is set. An override input replaces the divided wave with the reference level itself and suppresses the periodic event. Each period of an active rate sets a sticky periodic flag. A status read strobe clears the flag. When the flag's enable is set, the flag raises an interrupt request. Flag and request are also presented as a status byte at fixed bit positions. Calendar counting is left to other logic.

Top module: `rate_wave_gen`

## Requirements
- R1: After a synchronous reset, `wave_o`, `irq_o` and all bits of `stat_o` are 0.
- R2: With the reference toggling at half the clock rate, rate codes 3 to 15 produce a wave of period 2^code clock cycles with a 50% duty cycle (reference frequency divided by 2^(code-1)).
- R3: Rate code 1 behaves as code 8 (period 256 cycles) and code 2 as code 9 (period 512 cycles).
- R4: Rate code 0 holds `wave_o` low and never sets the periodic flag.
- R5: With `wave_en` low and no override, `wave_o` stays low while the periodic flag keeps counting periods.
- R6: With `ref_ovr` high, `wave_o` follows the reference level whatever the rate code and `wave_en` are, the periodic flag is never set, and `irq_o` stays low.
- R7: The periodic flag sets once per period of an active rate and stays set until `stat_rd` is pulsed. A new set in the same cycle as the read wins over the clear.
- R8: `irq_o` is high exactly when the flag is set and `pflag_en` is high.
- R9: `stat_o` carries the flag in bit 6 and the request in bit 7. Bits 5..0 always read 0.
- R10: A change of rate code takes effect at the next tap edge without restarting the divider. The next full period is the period of the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | 32768 Hz reference level |
| rate_sel | input | 4 | Rate code |
| wave_en | input | 1 | Gates the divided wave onto `wave_o` |
| ref_ovr | input | 1 | Puts the raw reference on `wave_o` and blocks periodic events |
| pflag_en | input | 1 | Lets the periodic flag raise a request |
| stat_rd | input | 1 | Status read strobe that clears the flag |
| wave_o | output | 1 | Square-wave output |
| stat_o | output | 8 | Status byte: bit 7 request, bit 6 flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted divider count or a wrong tap choice shows at once as a wrong period or duty cycle on `wave_o`. It also shows as a wrong number of flag events per window, visible within one or two periods of the selected rate. A flag register that loses or invents events shows at the next read strobe, when the status byte or the request disagrees with the event count. Leakage of the override or code 0 into the event path shows as a flag set within one tap period.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int STAT_W        = 8;
  localparam int STAT_FLAG_BIT = 6;
  localparam int STAT_REQ_BIT  = 7;

  // Alias codes map onto the taps of the codes they duplicate.
  localparam int ALIAS_A_CODE  = 1;
  localparam int ALIAS_A_TWIN  = 8;
  localparam int ALIAS_B_CODE  = 2;
  localparam int ALIAS_B_TWIN  = 9;
  localparam int CODE_TO_TAP   = 2;  // code c uses divider bit c-2

  // Divider bit used for a rate code. Code 0 is handled outside.
  function automatic int unsigned tap_of(input int unsigned code);
    int unsigned eff;
    if (code == ALIAS_A_CODE)      eff = ALIAS_A_TWIN;
    else if (code == ALIAS_B_CODE) eff = ALIAS_B_TWIN;
    else                           eff = code;
    if (eff < CODE_TO_TAP) return 0;
    return eff - CODE_TO_TAP;
  endfunction
endpackage

// File: rtl/pwg_ref_sync.sv
module pwg_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_lvl,
  output logic ref_rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              lvl_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= ref_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= chain[LAST];
  end

  assign ref_lvl  = chain[LAST];
  assign ref_rise = chain[LAST] & ~lvl_d;
endmodule

// File: rtl/pwg_divider.sv
module pwg_divider #(
  parameter int DIV_W  = 14,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [CODE_W-1:0] rate_sel,
  output logic              tap
);
  import pwg_pkg::*;

  logic [DIV_W-1:0] cnt;
  int unsigned      idx;

  // The count never restarts on a code change; only reset clears it.
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  always_comb begin
    idx = tap_of(int'(rate_sel));
    tap = 1'b0;
    for (int k = 0; k < DIV_W; k++) begin
      if (idx == k) tap = cnt[k];
    end
  end
endmodule

// File: rtl/pwg_flag.sv
module pwg_flag (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic active,
  input  logic rd,
  input  logic ie,
  input  logic ovr,
  output logic flag,
  output logic req
);
  logic tap_d;
  logic rise;
  logic nxt;

  assign rise = tap & ~tap_d;
  // A set in the same cycle as a read wins, so no event is lost.
  assign nxt  = (rise & active) | (flag & ~rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_d <= 1'b0;
      flag  <= 1'b0;
      req   <= 1'b0;
    end else begin
      tap_d <= tap;
      flag  <= nxt;
      req   <= nxt & ie & ~ovr;
    end
  end
endmodule

// File: rtl/rate_wave_gen.sv
module rate_wave_gen #(
  parameter int DIV_W     = 14,
  parameter int CODE_W    = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              wave_en,
  input  logic              ref_ovr,
  input  logic              pflag_en,
  input  logic              stat_rd,
  output logic              wave_o,
  output logic [7:0]        stat_o,
  output logic              irq_o
);
  import pwg_pkg::*;

  logic ref_lvl, ref_rise, tap, rate_on, active, flag, req, wave_q;

  pwg_ref_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .ref_in(ref_in),
    .ref_lvl(ref_lvl), .ref_rise(ref_rise)
  );

  pwg_divider #(.DIV_W(DIV_W), .CODE_W(CODE_W)) u_div (
    .clk(clk), .rst(rst), .step(ref_rise), .rate_sel(rate_sel), .tap(tap)
  );

  assign rate_on = (rate_sel != '0);
  assign active  = rate_on & ~ref_ovr;

  pwg_flag u_flag (
    .clk(clk), .rst(rst), .tap(tap), .active(active), .rd(stat_rd),
    .ie(pflag_en), .ovr(ref_ovr), .flag(flag), .req(req)
  );

  always_ff @(posedge clk) begin
    if (rst)          wave_q <= 1'b0;
    else if (ref_ovr) wave_q <= ref_lvl;
    else              wave_q <= wave_en & rate_on & tap;
  end

  always_comb begin
    stat_o                = '0;
    stat_o[STAT_FLAG_BIT] = flag;
    stat_o[STAT_REQ_BIT]  = req;
  end

  assign wave_o = wave_q;
  assign irq_o  = req;
endmodule

// File: rtl/pwg_chk.sv
module pwg_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] rate_sel,
  input logic              wave_en,
  input logic              ref_ovr,
  input logic              pflag_en,
  input logic              stat_rd,
  input logic              wave_o,
  input logic [7:0]        stat_o,
  input logic              irq_o
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (stat_o == 8'h00 && !wave_o && !irq_o));

  // R4, R5
  a_r4_quiet_wave: assert property (@(posedge clk) disable iff (rst)
    (!ref_ovr && (rate_sel == '0 || !wave_en)) |=> !wave_o);

  // R4, R6
  a_r6_no_flag_when_off: assert property (@(posedge clk) disable iff (rst)
    ((ref_ovr || rate_sel == '0) && stat_rd) |=> !stat_o[6]);

  // R6
  a_r6_ovr_no_req: assert property (@(posedge clk) disable iff (rst)
    ref_ovr |=> !irq_o);

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat_o[6] && !stat_rd) |=> stat_o[6]);

  // R8
  a_r8_req_needs_en: assert property (@(posedge clk) disable iff (rst)
    !pflag_en |=> !irq_o);

  a_r8_req_has_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> stat_o[6]);

  // R9
  a_r9_status_layout: assert property (@(posedge clk) disable iff (rst)
    (stat_o[5:0] == 6'd0 && stat_o[7] == irq_o));
endmodule

bind rate_wave_gen pwg_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .rate_sel(rate_sel), .wave_en(wave_en),
  .ref_ovr(ref_ovr), .pflag_en(pflag_en), .stat_rd(stat_rd),
  .wave_o(wave_o), .stat_o(stat_o), .irq_o(irq_o)
);

// File: tb/rate_wave_gen_test.sv
module rate_wave_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       wave_en = 1'b0, ref_ovr = 1'b0, pflag_en = 1'b0, stat_rd = 1'b0;
  logic       wave_o, irq_o;
  logic [7:0] stat_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rate_wave_gen uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .rate_sel(rate_sel),
    .wave_en(wave_en), .ref_ovr(ref_ovr), .pflag_en(pflag_en),
    .stat_rd(stat_rd), .wave_o(wave_o), .stat_o(stat_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  // Reference toggles every clock: half the clock rate.
  initial forever begin
    @(posedge clk);
    ref_in <= ~ref_in;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // Cycles between two rising edges of wave_o, and high cycles within.
  task automatic measure(output int per, output int hi);
    bit prev;
    int guard;
    per = 0; hi = 0; guard = 0;
    @(negedge clk); prev = wave_o;
    while (!(wave_o && !prev) && guard < 70000) begin
      prev = wave_o; @(negedge clk); guard++;
    end
    hi = 1; prev = 1'b1;
    forever begin
      @(negedge clk); per++;
      if (wave_o && !prev) break;
      if (wave_o) hi++;
      prev = wave_o;
      if (per > 70000) break;
    end
  endtask

  task automatic count_flags(input int cycles, output int n, output int wrise);
    bit pf, pw;
    n = 0; wrise = 0;
    @(negedge clk); pf = stat_o[6]; pw = wave_o;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (stat_o[6] && !pf) n++;
      if (wave_o && !pw) wrise++;
      pf = stat_o[6]; pw = wave_o;
    end
  endtask

  task automatic t_reset();
    check(stat_o == 8'h00, "R1 stat", stat_o, 0);
    check(!wave_o && !irq_o, "R1 wave/irq", {wave_o, irq_o}, 0);
  endtask

  task automatic t_rates();
    int per, hi;
    int codes[3] = '{3, 6, 15};
    wave_en = 1;
    foreach (codes[i]) begin
      rate_sel = 4'(codes[i]);
      measure(per, hi);
      check(per == (1 << codes[i]), "R2 period", per, 1 << codes[i]);
      check(hi == (1 << (codes[i] - 1)), "R2 duty", hi, 1 << (codes[i] - 1));
    end
  endtask

  task automatic t_alias();
    int per, hi;
    rate_sel = 4'd1; measure(per, hi);
    check(per == 256, "R3 code1", per, 256);
    rate_sel = 4'd2; measure(per, hi);
    check(per == 512, "R3 code2", per, 512);
  endtask

  task automatic t_change();
    int per, hi;
    rate_sel = 4'd3; measure(per, hi);
    rate_sel = 4'd5; measure(per, hi);
    check(per == 32, "R10 new rate", per, 32);
  endtask

  task automatic t_zero();
    int n, w;
    @(negedge clk); rate_sel = 4'd0; wave_en = 1; stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    count_flags(300, n, w);
    check(n == 0 && stat_o[6] == 0, "R4 flag", n, 0);
    check(w == 0 && !wave_o, "R4 wave", w, 0);
  endtask

  task automatic t_gate();
    int n, w;
    @(negedge clk); rate_sel = 4'd3; wave_en = 0; stat_rd = 1;
    count_flags(160, n, w);
    check(w == 0, "R5 wave gated", w, 0);
    check(n >= 19 && n <= 21, "R7 one flag per period", n, 20);
    stat_rd = 0;
  endtask

  task automatic t_flag();
    int guard = 0;
    @(negedge clk); rate_sel = 4'd3; pflag_en = 0; stat_rd = 0;
    while (!stat_o[6] && guard < 100) begin @(negedge clk); guard++; end
    check(stat_o[6], "R7 flag set", stat_o[6], 1);
    repeat (20) @(negedge clk);
    check(stat_o[6], "R7 sticky", stat_o[6], 1);
    check(!irq_o, "R8 no req without enable", irq_o, 0);
    pflag_en = 1;
    @(negedge clk);
    check(irq_o, "R8 req", irq_o, 1);
    check(stat_o == 8'hC0, "R9 layout", stat_o, 8'hC0);
    rate_sel = 4'd0; stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    check(stat_o == 8'h00, "R7 cleared", stat_o, 0);
    check(!irq_o, "R8 req drops", irq_o, 0);
  endtask

  task automatic t_ovr();
    int n, w;
    @(negedge clk); rate_sel = 4'd3; pflag_en = 1; ref_ovr = 1; wave_en = 0; stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    count_flags(100, n, w);
    check(w >= 49 && w <= 51, "R6 raw reference", w, 50);
    check(n == 0 && !stat_o[6], "R6 no flag", n, 0);
    check(!irq_o, "R6 no req", irq_o, 0);
    ref_ovr = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_rates();
    t_alias();
    t_change();
    t_zero();
    t_gate();
    t_flag();
    t_ovr();
    finish_run();
  end
endmodule